// File: doc/BRIEF.md
# Raster Timing Generator with Scaled Pixel Serializer

This block produces the horizontal and vertical raster timing for a video gate array. It also reads display bytes from RAM in a fixed window of each displayed line and turns each byte into a stream of one-bit pixels. A free-running position counter steps through the cycles of a line and through the lines of a frame. From that position the block derives the sync pulses, a RAM fetch slot once in every eight cycles, and the point at which the returned byte is captured.

Captured bytes pass through an eight-entry pixel buffer. A pixel run starts only once a byte has been captured and the serializer is idle. The run stops when the buffer has been used up. Each pixel is held for a programmable number of cycles, which stretches the picture horizontally. A character-row gap request blanks the output and also stalls both fetching and the serializer. A pending non-maskable interrupt suppresses RAM fetches. Palette lookup and bits-per-pixel decoding sit outside this block, so each pixel is a single bit.

Top module: `raster_pixel_engine`

## Requirements
- R1: While reset is high, and on the first clock after it, every output is 0.
- R2: A line lasts LINE_CYCLES clocks and the position wraps to 0 after the last one. `hsync_o` is high for the first HSYNC_LEN positions of every line. Each output shows the position of the previous clock.
- R3: The line counter wraps to 0 after TOTAL_LINES lines. `vsync_o` is high for the whole of line 0, one clock late like the other outputs.
- R4: A fetch takes place at position p only if all of these hold: p mod 8 = 0; FETCH_START <= p < FETCH_START+ACTIVE_W; the line lies in [FRAME_TOP, FRAME_TOP+FRAME_LINES); and neither `nmi_i` nor `row_gap_i` is high. `ram_rd_o` pulses for one clock after each fetch.
- R5: The video address is ADDR_W = 16 bits wide. It reloads to BASE_ADDR at line 0, position 0, and increases by 1 after every fetch. Each fetch drives `ram_row_o` with address bits [15:7] and `ram_col_o` with bits [6:0]. Both hold their value until the next fetch.
- R6: `ram_data_i` is captured at the position 4 cycles after the fetch slot (p mod 8 = 4). A newer byte replaces a byte that has not yet been used.
- R7: When the serializer is idle and a captured byte is waiting, the next clock loads that byte into the buffer and outputs blank. Pixels then leave MSB first, starting on the clock after the load.
- R8: `scale_i` is sampled at position 0 of each line. A load latches that sample plus 1 as the number of clocks each pixel lasts for the whole run. After 8 pixels the serializer goes idle.
- R9: `colour_o` is 0 while the serializer is idle. While `row_gap_i` is high it is also 0, and the serializer does not move forward.
- R10: While `nmi_i` is high no fetch happens. The address does not advance and no new byte is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| scale_i | input | SCALE_W | Horizontal stretch: clocks per pixel minus 1 |
| row_gap_i | input | 1 | Character-row spacing blank request |
| nmi_i | input | 1 | Non-maskable interrupt pending, inhibits fetches |
| ram_data_i | input | 8 | Byte returned by RAM |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| ram_rd_o | output | 1 | One-clock fetch strobe |
| ram_row_o | output | ADDR_W-COL_W | RAM row address (address bits above the column field) |
| ram_col_o | output | COL_W | RAM column address |
| colour_o | output | 1 | Serialized pixel, 0 when blank |

## Verification
A wrong position count moves the sync edges and the fetch strobes, so the error appears on `hsync_o` or `ram_rd_o` within one line. A wrong address count appears on the row and column pins at the next fetch. A wrong buffer index, stretch count or idle flag changes `colour_o`. This shows up within one pixel run: a pixel at the wrong position, a run of the wrong length, or output that fails to blank during a row gap. Scale values change from frame to frame, and nmi and gap pulses are placed inside the fetch window, so each of these paths is exercised.

// File: rtl/rpe_pkg.sv
package rpe_pkg;
  localparam int SLOT_W       = 3;              // 8 clocks per memory slot
  localparam int FETCH_PHASE  = 0;
  localparam int CAPTURE_PHASE = 4;
endpackage

// File: rtl/raster_counter.sv
module raster_counter #(
  parameter int LINE_CYCLES = 1024,
  parameter int TOTAL_LINES = 312,
  parameter int HSYNC_LEN   = 75,
  localparam int HW = $clog2(LINE_CYCLES),
  localparam int VW = $clog2(TOTAL_LINES)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [HW-1:0] h_o,
  output logic [VW-1:0] v_o,
  output logic          hsync_o,
  output logic          vsync_o
);
  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      h_q <= '0; v_q <= '0; hsync_o <= 1'b0; vsync_o <= 1'b0;
    end else begin
      hsync_o <= int'(h_q) < HSYNC_LEN;
      vsync_o <= (v_q == '0);
      if (int'(h_q) == LINE_CYCLES - 1) begin
        h_q <= '0;
        v_q <= (int'(v_q) == TOTAL_LINES - 1) ? '0 : v_q + 1'b1;
      end else begin
        h_q <= h_q + 1'b1;
      end
    end
  end

  assign h_o = h_q;
  assign v_o = v_q;

  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    int'(h_q) == LINE_CYCLES - 1 |=> h_q == '0);
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    int'(h_q) != LINE_CYCLES - 1 |=> h_q == $past(h_q) + 1'b1);
endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import rpe_pkg::*;
#(
  parameter int HW          = 10,
  parameter int VW          = 9,
  parameter int FETCH_START = 256,
  parameter int ACTIVE_W    = 640,
  parameter int FRAME_TOP   = 0,
  parameter int FRAME_LINES = 256,
  parameter int ADDR_W      = 16,
  parameter int COL_W       = 7,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  localparam int ROW_W = ADDR_W - COL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [HW-1:0]    h_i,
  input  logic [VW-1:0]    v_i,
  input  logic             nmi_i,
  input  logic             gap_i,
  output logic             ram_rd_o,
  output logic [ROW_W-1:0] ram_row_o,
  output logic [COL_W-1:0] ram_col_o,
  output logic             cap_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              pend_q;
  logic              in_win, in_frame, access;

  always_comb begin
    in_win   = int'(h_i) >= FETCH_START && int'(h_i) < FETCH_START + ACTIVE_W;
    in_frame = int'(v_i) >= FRAME_TOP && int'(v_i) < FRAME_TOP + FRAME_LINES;
    access   = (int'(h_i[SLOT_W-1:0]) == FETCH_PHASE) && in_win && in_frame
               && !nmi_i && !gap_i;
    cap_o    = pend_q && (int'(h_i[SLOT_W-1:0]) == CAPTURE_PHASE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= BASE_ADDR; pend_q <= 1'b0; ram_rd_o <= 1'b0;
      ram_row_o <= '0; ram_col_o <= '0;
    end else begin
      ram_rd_o <= access;
      if (access) begin
        ram_row_o <= addr_q[ADDR_W-1:COL_W];
        ram_col_o <= addr_q[COL_W-1:0];
      end
      if (h_i == '0 && v_i == '0) addr_q <= BASE_ADDR;
      else if (access)            addr_q <= addr_q + 1'b1;
      if (access)     pend_q <= 1'b1;
      else if (cap_o) pend_q <= 1'b0;
    end
  end

  a_r4_slot: assert property (@(posedge clk) disable iff (rst)
    ram_rd_o |-> h_i[SLOT_W-1:0] == 3'd1);
  a_r10_nmi_block: assert property (@(posedge clk) disable iff (rst)
    nmi_i |=> !ram_rd_o);
endmodule

// File: rtl/pixel_shifter.sv
module pixel_shifter #(
  parameter int HW        = 10,
  parameter int BUF_DEPTH = 8,
  parameter int SCALE_W   = 2,
  localparam int IW = $clog2(BUF_DEPTH),
  localparam int CW = SCALE_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [HW-1:0]        h_i,
  input  logic [SCALE_W-1:0]   scale_i,
  input  logic                 cap_i,
  input  logic [BUF_DEPTH-1:0] data_i,
  input  logic                 gap_i,
  output logic                 colour_o
);
  logic [BUF_DEPTH-1:0] hold_q, buf_q;
  logic                 have_q, run_q, load;
  logic [IW-1:0]        idx_q;
  logic [CW-1:0]        line_rep_q, run_rep_q, cnt_q;

  assign load = !run_q && have_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0; buf_q <= '0; have_q <= 1'b0; run_q <= 1'b0;
      idx_q <= '0; cnt_q <= CW'(1); line_rep_q <= CW'(1); run_rep_q <= CW'(1);
      colour_o <= 1'b0;
    end else begin
      if (h_i == '0) line_rep_q <= CW'(scale_i) + 1'b1;
      if (cap_i) hold_q <= data_i;
      if (cap_i)     have_q <= 1'b1;
      else if (load) have_q <= 1'b0;

      if (load) begin
        buf_q <= hold_q; idx_q <= '0; cnt_q <= line_rep_q;
        run_rep_q <= line_rep_q; run_q <= 1'b1; colour_o <= 1'b0;
      end else if (run_q && !gap_i) begin
        colour_o <= buf_q[BUF_DEPTH-1-int'(idx_q)];
        if (cnt_q == CW'(1)) begin
          cnt_q <= run_rep_q;
          if (int'(idx_q) == BUF_DEPTH - 1) begin
            run_q <= 1'b0; idx_q <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else begin
        colour_o <= 1'b0;
      end
    end
  end

  a_r9_gap_blank: assert property (@(posedge clk) disable iff (rst)
    gap_i |=> !colour_o);
  a_r8_hold_pixel: assert property (@(posedge clk) disable iff (rst)
    run_q && !gap_i && cnt_q != CW'(1) |=> $stable(idx_q));
endmodule

// File: rtl/raster_pixel_engine.sv
module raster_pixel_engine #(
  parameter int LINE_CYCLES = 1024,
  parameter int TOTAL_LINES = 312,
  parameter int HSYNC_LEN   = 75,
  parameter int FETCH_START = 256,
  parameter int ACTIVE_W    = 640,
  parameter int FRAME_TOP   = 0,
  parameter int FRAME_LINES = 256,
  parameter int ADDR_W      = 16,
  parameter int COL_W       = 7,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h3000,
  parameter int SCALE_W     = 2,
  parameter int BUF_DEPTH   = 8,
  localparam int HW    = $clog2(LINE_CYCLES),
  localparam int VW    = $clog2(TOTAL_LINES),
  localparam int ROW_W = ADDR_W - COL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic               row_gap_i,
  input  logic               nmi_i,
  input  logic [7:0]         ram_data_i,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               ram_rd_o,
  output logic [ROW_W-1:0]   ram_row_o,
  output logic [COL_W-1:0]   ram_col_o,
  output logic               colour_o
);
  logic [HW-1:0] h;
  logic [VW-1:0] v;
  logic          cap;

  raster_counter #(.LINE_CYCLES(LINE_CYCLES), .TOTAL_LINES(TOTAL_LINES),
                   .HSYNC_LEN(HSYNC_LEN)) u_cnt (
    .clk(clk), .rst(rst), .h_o(h), .v_o(v),
    .hsync_o(hsync_o), .vsync_o(vsync_o));

  fetch_ctrl #(.HW(HW), .VW(VW), .FETCH_START(FETCH_START), .ACTIVE_W(ACTIVE_W),
               .FRAME_TOP(FRAME_TOP), .FRAME_LINES(FRAME_LINES),
               .ADDR_W(ADDR_W), .COL_W(COL_W), .BASE_ADDR(BASE_ADDR)) u_fetch (
    .clk(clk), .rst(rst), .h_i(h), .v_i(v), .nmi_i(nmi_i), .gap_i(row_gap_i),
    .ram_rd_o(ram_rd_o), .ram_row_o(ram_row_o), .ram_col_o(ram_col_o),
    .cap_o(cap));

  pixel_shifter #(.HW(HW), .BUF_DEPTH(BUF_DEPTH), .SCALE_W(SCALE_W)) u_pix (
    .clk(clk), .rst(rst), .h_i(h), .scale_i(scale_i), .cap_i(cap),
    .data_i(ram_data_i[BUF_DEPTH-1:0]), .gap_i(row_gap_i), .colour_o(colour_o));
endmodule

// File: tb/tb_raster_pixel_engine.sv
module tb_raster_pixel_engine;
  localparam int LC = 128, TL = 8, HS = 12, FS = 32, AW = 64, FT = 2, FL = 4;
  localparam int BASE = 16'h3000;

  logic clk = 0, rst = 1;
  logic [1:0] scale_i = 0;
  logic row_gap_i = 0, nmi_i = 0;
  logic [7:0] ram_data_i;
  logic hsync_o, vsync_o, ram_rd_o, colour_o;
  logic [8:0] ram_row_o;
  logic [6:0] ram_col_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  raster_pixel_engine #(.LINE_CYCLES(LC), .TOTAL_LINES(TL), .HSYNC_LEN(HS),
    .FETCH_START(FS), .ACTIVE_W(AW), .FRAME_TOP(FT), .FRAME_LINES(FL),
    .BASE_ADDR(16'h3000)) dut (
    .clk(clk), .rst(rst), .scale_i(scale_i), .row_gap_i(row_gap_i), .nmi_i(nmi_i),
    .ram_data_i(ram_data_i), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .ram_rd_o(ram_rd_o), .ram_row_o(ram_row_o), .ram_col_o(ram_col_o),
    .colour_o(colour_o));

  function automatic int mem_byte(int row, int col);
    return (row * 7 + col * 13 + 5) & 255;
  endfunction

  assign ram_data_i = 8'(mem_byte(int'(ram_row_o), int'(ram_col_o)));

  // reference model state
  int m_h, m_v, m_addr, m_row, m_col, m_hold, m_rep, m_lrep;
  bit m_hs, m_vs, m_rd, m_col_px, m_pend, m_have;
  bit pq[$];

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at t=%0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic model_reset();
    m_h = 0; m_v = 0; m_addr = BASE; m_row = 0; m_col = 0; m_hold = 0;
    m_lrep = 1; m_hs = 0; m_vs = 0; m_rd = 0; m_col_px = 0;
    m_pend = 0; m_have = 0; pq.delete();
  endtask

  task automatic model_step();
    bit acc, cap, idle;
    acc = (m_h % 8 == 0) && m_h >= FS && m_h < FS + AW && m_v >= FT &&
          m_v < FT + FL && !nmi_i && !row_gap_i;           // R4, R10
    cap = m_pend && (m_h % 8 == 4);                        // R6
    idle = (pq.size() == 0);
    m_hs = (m_h < HS);                                     // R2
    m_vs = (m_v == 0);                                     // R3
    m_rd = acc;
    if (acc) begin m_row = m_addr >> 7; m_col = m_addr & 127; end  // R5
    if (idle && m_have) begin                              // R7
      for (int b = 7; b >= 0; b--)
        for (int k = 0; k < m_lrep; k++) pq.push_back(m_hold[b]);  // R8
      m_col_px = 0;
      m_have = 0;
    end else if (!idle && !row_gap_i) begin
      m_col_px = pq.pop_front();
    end else begin
      m_col_px = 0;                                        // R9
    end
    if (cap) begin m_hold = mem_byte(m_row, m_col); m_have = 1; end
    if (m_h == 0) m_lrep = scale_i + 1;
    if (m_h == 0 && m_v == 0) m_addr = BASE;
    else if (acc) m_addr = (m_addr + 1) & 16'hFFFF;
    if (acc) m_pend = 1; else if (cap) m_pend = 0;
    if (m_h == LC - 1) begin m_h = 0; m_v = (m_v == TL - 1) ? 0 : m_v + 1; end
    else m_h++;
  endtask

  task automatic set_inputs(int c);
    int fr, ln, hp;
    fr = c / (LC * TL); ln = (c / LC) % TL; hp = c % LC;
    case (fr % 4)
      0: scale_i = 2'd0;
      1: scale_i = 2'd1;
      2: scale_i = 2'd3;
      default: scale_i = 2'd2;
    endcase
    // R9: row gap over a whole line in some frames, short pulses in others
    row_gap_i = (fr % 2 == 1 && ln == 3) || (ln == 4 && hp >= 50 && hp < 58);
    // R10: nmi burst inside the fetch window
    nmi_i = (ln == 2 && hp >= 40 && hp < 70) || (fr == 3 && ln == 5);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs cleared in reset
    chk("R1 hsync", hsync_o, 0); chk("R1 vsync", vsync_o, 0);
    chk("R1 rd", ram_rd_o, 0);   chk("R1 colour", colour_o, 0);
    chk("R1 row", ram_row_o, 0); chk("R1 col", ram_col_o, 0);
    rst = 0;
    set_inputs(0);
    model_step();
    for (int c = 1; c < LC * TL * 5; c++) begin
      @(negedge clk);
      chk("R2 hsync", hsync_o, m_hs);
      chk("R3 vsync", vsync_o, m_vs);
      chk("R4/R10 ram_rd", ram_rd_o, m_rd);
      chk("R5 ram_row", ram_row_o, m_row);
      chk("R5 ram_col", ram_col_o, m_col);
      chk("R6/R7/R8/R9 colour", colour_o, m_col_px);
      set_inputs(c);
      model_step();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule